// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send and Request-to-Send Control

This block turns parallel characters into an asynchronous serial stream. A one-character holding register sits in front of a shift register, so the next character can be written while the current one is on the line. Each character goes out as a start bit, then 5 to 8 data bits with the least significant bit first, then an optional bit (parity, a forced value, or a multidrop address/data tag), then a stop period. The stop period can be set in sixteenths of a bit. All bit timing comes from a 16x bit-rate enable pulse supplied by the surrounding logic.

Flow control works in both directions. When checking is on, an active-low clear-to-send input is looked at only at the moment a character is about to begin. An active-low request-to-send output can be raised automatically one bit time after the last character has left, once a disable is pending. Single-cycle command strobes enable, disable, reset and break the transmitter. The state machine has six states. ST_IDLE waits for a character. ST_START drives the start bit. ST_DATA shifts out the data bits. ST_PARITY sends the extra bit. ST_STOP holds the line high for the stop period. ST_RTS_WAIT counts one bit time before request-to-send is negated. The named transitions are:
- IDLE→START when a character can begin.
- START→DATA after 16 ticks.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP after 16 ticks.
- STOP→START when the next character is ready (back-to-back).
- STOP→RTS_WAIT when disabled with auto-RTS on.
- STOP→IDLE otherwise.
- RTS_WAIT→IDLE after 16 ticks.
- Any state →IDLE on the reset command.

Top module: `uart_tx_flow`

## Requirements
- R1: After `rst_n` is released, `txd`=1, `rts_n`=1, `tx_ready`=0 and `tx_empty`=0.
- R2: A frame is one low start bit of 16 ticks, then N=5+`cfg_len` data bits (`cfg_len` 00→5 … 11→8) sent least significant bit first, each 16 ticks long. Bits of `ld_data` at or above N are not sent.
- R3: `cfg_par_mode` selects the bit after the data. With 00 a parity bit is sent: `cfg_par_sel`=0 gives even, 1 gives odd. With 01 the value of `cfg_par_sel` is sent. With 10 no bit is sent. With 11 (multidrop) `cfg_par_sel` is sent as the address/data tag. Parity is computed over the N active data bits only.
- R4: The stop period is 17+`cfg_stop` ticks. The exception is when N>5 and `cfg_stop`<8: then it is 9+`cfg_stop` ticks. For 5-bit characters the range is therefore 1 1/16 to 2 bits.
- R5: `cmd_enable` sets `tx_ready`. An accepted load clears it on the next clock. It is set again when the character moves into the shift register, at the next tick.
- R6: `tx_empty` is 1 when enabled, with the holding register empty and no character on the line. An accepted load clears it.
- R7: A load is ignored while the transmitter is disabled, and also while the holding register is full.
- R8: `cmd_disable` lets the character already in the shift register finish. No further character starts, including one waiting in the holding register.
- R9: `cmd_reset` returns the line to high on the next clock. It discards the held character and clears the enable, so `tx_ready`=0 and `tx_empty`=0 until `cmd_enable`.
- R10: With `cfg_cts_en`=1, a character starts only while `cts_n` (synchronised) is low. While `cts_n` is high the line stays high. A change of `cts_n` during a character has no effect on that character.
- R11: Between `cmd_break_on` and `cmd_break_off`, `txd` is held low and no character starts. A character loaded during the break is sent after it ends.
- R12: `cmd_enable` drives `rts_n` low. With `cfg_rts_auto`=1 and the transmitter disabled when a character's stop period ends, `rts_n` rises 16 ticks after the end of the stop period. With `cfg_rts_auto`=0, `rts_n` is unaffected.
- R13: If the next character is held and allowed to start when a stop period ends, its start bit begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| cfg_len | input | 2 | Character length code, N=5+code |
| cfg_par_mode | input | 2 | Extra-bit mode: 00 parity, 01 forced, 10 none, 11 multidrop |
| cfg_par_sel | input | 1 | Parity sense, forced value or address/data tag |
| cfg_stop | input | 4 | Stop period code |
| cfg_cts_en | input | 1 | Gate character starts on clear-to-send |
| cfg_rts_auto | input | 1 | Negate request-to-send after the last character once disabled |
| cmd_enable | input | 1 | Enable strobe |
| cmd_disable | input | 1 | Disable strobe |
| cmd_reset | input | 1 | Transmitter reset strobe |
| cmd_break_on | input | 1 | Begin break strobe |
| cmd_break_off | input | 1 | End break strobe |
| ld_strobe | input | 1 | Write ld_data into the holding register |
| ld_data | input | 8 | Character to send |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial output |
| rts_n | output | 1 | Request-to-send, active low |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding and shift registers both idle |

## Verification
The bench builds the block with its default parameters: an 8-bit character limit and a two-stage clear-to-send synchroniser. The 16x enable is driven every second clock, so each bit lasts 32 clocks and complete frames fit in a short run. This makes an exhaustive sweep practical: every character length against every extra-bit mode and both select values, and every stop code at both the 5-bit and 8-bit lengths. Back-to-back pairs are used to measure the stop period exactly.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    localparam int CHAR_MAX      = 8;
    localparam int TICKS_PER_BIT = 16;
    localparam int SEG_CNT_W     = $clog2(2 * TICKS_PER_BIT);
    localparam int BIT_IDX_W     = $clog2(CHAR_MAX);
    localparam int STOP_W        = SEG_CNT_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_RTS_WAIT
    } tx_state_t;

    typedef enum logic [1:0] {
        PM_PARITY = 2'b00,
        PM_FORCED = 2'b01,
        PM_NONE   = 2'b10,
        PM_MDROP  = 2'b11
    } par_mode_t;

    function automatic logic [3:0] char_len(input logic [1:0] len_code);
        return 4'd5 + {2'b00, len_code};
    endfunction

    // stop period in 16x ticks
    function automatic logic [STOP_W-1:0] stop_len(input logic [1:0] len_code,
                                                   input logic [3:0] code);
        if (len_code != 2'b00 && !code[3])
            return STOP_W'(9) + STOP_W'(code);
        else
            return STOP_W'(17) + STOP_W'(code);
    endfunction

    function automatic logic extra_bit(input logic [CHAR_MAX-1:0] data,
                                       input logic [1:0] len_code,
                                       input logic [1:0] mode,
                                       input logic sel);
        logic [CHAR_MAX-1:0] active;
        logic                ones_odd;
        for (int i = 0; i < CHAR_MAX; i++)
            active[i] = data[i] & (i < int'(char_len(len_code)));
        ones_odd = ^active;
        case (par_mode_t'(mode))
            PM_PARITY: return sel ? ~ones_odd : ones_odd;
            PM_FORCED: return sel;
            PM_MDROP:  return sel;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uatx_sync.sv
module uatx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RESET_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/uatx_ctrl.sv
module uatx_ctrl
    import uatx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_enable,
    input  logic                cmd_disable,
    input  logic                cmd_reset,
    input  logic                cmd_break_on,
    input  logic                cmd_break_off,
    input  logic                ld_strobe,
    input  logic [CHAR_MAX-1:0] ld_data,
    input  logic                take,
    output logic                en_q,
    output logic                brk_q,
    output logic                hold_full,
    output logic [CHAR_MAX-1:0] hold_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            brk_q <= 1'b0;
        end else if (cmd_reset) begin
            en_q  <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            if (cmd_enable)        en_q <= 1'b1;
            else if (cmd_disable)  en_q <= 1'b0;
            if (cmd_break_on)      brk_q <= 1'b1;
            else if (cmd_break_off) brk_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (cmd_reset || take) begin
            hold_full <= 1'b0;
        end else if (ld_strobe && en_q && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= ld_data;
        end
    end

    p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !hold_full) else $error("take did not free holding register");

    p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && !en_q && !cmd_reset) |=> ($stable(hold_data) && hold_full == $past(hold_full)))
        else $error("load accepted while disabled");
endmodule

// File: rtl/uatx_fsm.sv
module uatx_fsm
    import uatx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                en,
    input  logic                brk,
    input  logic                cmd_enable,
    input  logic                cmd_reset,
    input  logic                hold_full,
    input  logic [CHAR_MAX-1:0] hold_data,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_par_mode,
    input  logic                cfg_par_sel,
    input  logic [3:0]          cfg_stop,
    input  logic                cfg_cts_en,
    input  logic                cfg_rts_auto,
    input  logic                cts_s,
    output logic                take,
    output logic                txd,
    output logic                rts_n,
    output logic                shifter_idle
);
    localparam logic [SEG_CNT_W-1:0] BIT_LAST = SEG_CNT_W'(TICKS_PER_BIT - 1);

    tx_state_t               state, nxt;
    logic [SEG_CNT_W-1:0]    cnt;
    logic [BIT_IDX_W-1:0]    bit_idx;
    logic [CHAR_MAX-1:0]     shreg;
    logic                    par_q;
    logic                    rts_q;
    logic [SEG_CNT_W-1:0]    seg_last;
    logic                    seg_end;
    logic                    start_ok;
    logic                    has_extra;
    logic [BIT_IDX_W-1:0]    last_idx;
    logic [STOP_W-1:0]       stop_ticks;

    assign stop_ticks = stop_len(cfg_len, cfg_stop);
    assign has_extra  = par_mode_t'(cfg_par_mode) != PM_NONE;
    assign last_idx   = BIT_IDX_W'(char_len(cfg_len) - 4'd1);
    assign start_ok   = hold_full && en && !brk && (!cfg_cts_en || !cts_s);

    always_comb begin
        unique case (state)
            ST_STOP: seg_last = SEG_CNT_W'(stop_ticks - STOP_W'(1));
            ST_IDLE: seg_last = '0;
            default: seg_last = BIT_LAST;
        endcase
    end

    assign seg_end = tick && (cnt == seg_last);

    // next-state logic
    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tick && start_ok) begin
                    nxt  = ST_START;
                    take = 1'b1;
                end
            end
            ST_START: begin
                if (seg_end) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (seg_end && bit_idx == last_idx)
                    nxt = has_extra ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (seg_end) nxt = ST_STOP;
            end
            ST_STOP: begin
                if (seg_end) begin
                    if (start_ok) begin
                        nxt  = ST_START;
                        take = 1'b1;
                    end else if (!en && cfg_rts_auto) begin
                        nxt = ST_RTS_WAIT;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_RTS_WAIT: begin
                if (seg_end) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        if (cmd_reset) begin
            nxt  = ST_IDLE;
            take = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            rts_q   <= 1'b1;
        end else begin
            if (nxt != state || nxt == ST_IDLE) cnt <= '0;
            else if (tick)                      cnt <= (cnt == seg_last) ? '0 : cnt + 1'b1;

            if (take) begin
                shreg   <= hold_data;
                bit_idx <= '0;
                par_q   <= extra_bit(hold_data, cfg_len, cfg_par_mode, cfg_par_sel);
            end else if (state == ST_DATA && seg_end) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end

            if (cmd_enable)
                rts_q <= 1'b0;
            else if (state == ST_RTS_WAIT && seg_end && !en)
                rts_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        logic line;
        unique case (state)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
        txd          = brk ? 1'b0 : line;
        rts_n        = rts_q;
        shifter_idle = (state == ST_IDLE) || (state == ST_RTS_WAIT);
    end

    p_take_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_full) else $error("character taken from empty holding register");

    p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && state != ST_START) |=> state != ST_START) else $error("start while disabled");

    p_rst_cmd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> state == ST_IDLE) else $error("reset command did not stop output");

    p_cts_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_en && cts_s && state != ST_START) |=> state != ST_START)
        else $error("start without clear-to-send");

    p_break_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && state != ST_START) |=> state != ST_START) else $error("start during break");

    p_rts_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> $past(state) == ST_RTS_WAIT) else $error("rts negated outside wait");
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uatx_pkg::*;
#(
    parameter int CTS_SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_par_mode,
    input  logic                cfg_par_sel,
    input  logic [3:0]          cfg_stop,
    input  logic                cfg_cts_en,
    input  logic                cfg_rts_auto,
    input  logic                cmd_enable,
    input  logic                cmd_disable,
    input  logic                cmd_reset,
    input  logic                cmd_break_on,
    input  logic                cmd_break_off,
    input  logic                ld_strobe,
    input  logic [CHAR_MAX-1:0] ld_data,
    input  logic                cts_n,
    output logic                txd,
    output logic                rts_n,
    output logic                tx_ready,
    output logic                tx_empty
);
    logic                en_q, brk_q, hold_full, take, cts_s, shifter_idle;
    logic [CHAR_MAX-1:0] hold_data;

    uatx_sync #(.STAGES(CTS_SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s)
    );

    uatx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .cmd_break_on(cmd_break_on), .cmd_break_off(cmd_break_off),
        .ld_strobe(ld_strobe), .ld_data(ld_data), .take(take),
        .en_q(en_q), .brk_q(brk_q), .hold_full(hold_full), .hold_data(hold_data)
    );

    uatx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .en(en_q), .brk(brk_q),
        .cmd_enable(cmd_enable), .cmd_reset(cmd_reset),
        .hold_full(hold_full), .hold_data(hold_data),
        .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode), .cfg_par_sel(cfg_par_sel),
        .cfg_stop(cfg_stop), .cfg_cts_en(cfg_cts_en), .cfg_rts_auto(cfg_rts_auto),
        .cts_s(cts_s), .take(take), .txd(txd), .rts_n(rts_n), .shifter_idle(shifter_idle)
    );

    assign tx_ready = en_q && !hold_full;
    assign tx_empty = en_q && !hold_full && shifter_idle;
endmodule

// File: tb/uart_tx_flow_tb_top.sv
`timescale 1ns/1ps
module uart_tx_flow_tb_top;
    localparam real CLK_P = 4.0;

    logic clk = 1'b0, rst_n = 1'b0, tick16;
    logic [1:0] cfg_len = 2'd3, cfg_par_mode = 2'b10;
    logic cfg_par_sel = 1'b0;
    logic [3:0] cfg_stop = 4'd0;
    logic cfg_cts_en = 1'b0, cfg_rts_auto = 1'b0;
    logic cmd_enable = 0, cmd_disable = 0, cmd_reset = 0, cmd_break_on = 0, cmd_break_off = 0;
    logic ld_strobe = 0;
    logic [7:0] ld_data = '0;
    logic cts_n = 1'b0;
    logic txd, rts_n, tx_ready, tx_empty;

    int n_tests = 0, n_fail = 0;

    uart_tx_flow dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(cfg_len),
        .cfg_par_mode(cfg_par_mode), .cfg_par_sel(cfg_par_sel), .cfg_stop(cfg_stop),
        .cfg_cts_en(cfg_cts_en), .cfg_rts_auto(cfg_rts_auto),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .cmd_break_on(cmd_break_on), .cmd_break_off(cmd_break_off),
        .ld_strobe(ld_strobe), .ld_data(ld_data), .cts_n(cts_n),
        .txd(txd), .rts_n(rts_n), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tick16 <= 1'b0;
        else        tick16 <= ~tick16;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_sample();
        do @(negedge clk); while (tick16 !== 1'b1);
    endtask

    task automatic wait_start();
        next_sample();
        while (txd !== 1'b0) next_sample();
    endtask

    // current sample is the first low sample of a start bit
    task automatic rx_frame(input int nb, input bit hp, input bit count_stop,
                            output logic [8:0] val, output int scnt);
        val = '0;
        repeat (8) next_sample();
        chk(txd === 1'b0, "R2 start bit low", int'(txd), 0);
        for (int i = 0; i < nb + int'(hp); i++) begin
            repeat (16) next_sample();
            val[i] = txd;
        end
        repeat (8) next_sample();
        scnt = 0;
        if (count_stop)
            while (txd === 1'b1 && scnt < 40) begin
                scnt++;
                next_sample();
            end
    endtask

    task automatic cmd(input int c);
        @(negedge clk);
        case (c)
            0: cmd_enable = 1;  1: cmd_disable = 1;  2: cmd_reset = 1;
            3: cmd_break_on = 1; default: cmd_break_off = 1;
        endcase
        @(negedge clk);
        {cmd_enable, cmd_disable, cmd_reset, cmd_break_on, cmd_break_off} = '0;
    endtask

    task automatic load(input logic [7:0] d);
        @(negedge clk);
        ld_strobe = 1; ld_data = d;
        @(negedge clk);
        ld_strobe = 0;
    endtask

    function automatic int stop_exp(input int len, input int code);
        return (len != 0 && code < 8) ? 9 + code : 17 + code;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] v, v2;
        int sc, sc2, cnt;
        bit bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1 && rts_n === 1, "R1 txd/rts after reset", {txd, rts_n}, 3);
        chk(tx_ready === 0 && tx_empty === 0, "R1 flags after reset", {tx_ready, tx_empty}, 0);

        cmd(0);
        chk(tx_ready === 1, "R5 ready after enable", tx_ready, 1);
        chk(tx_empty === 1, "R6 empty after enable", tx_empty, 1);
        chk(rts_n === 0, "R12 rts asserted on enable", rts_n, 0);

        // R2/R3 sweep of length, extra-bit mode and select
        for (int len = 0; len < 4; len++)
            for (int pm = 0; pm < 4; pm++)
                for (int sel = 0; sel < 2; sel++) begin
                    logic [7:0] d, m;
                    int nb;
                    bit hp, pexp;
                    d = 8'(8'h96 + len * 53 + pm * 29 + sel * 7);
                    nb = 5 + len;
                    hp = (pm != 2);
                    m = 8'((1 << nb) - 1);
                    pexp = (pm == 0) ? ((^(d & m)) ^ sel) : sel;
                    cfg_len = 2'(len); cfg_par_mode = 2'(pm); cfg_par_sel = sel[0];
                    cfg_stop = 4'd0;
                    fork
                        load(d);
                        begin wait_start(); rx_frame(nb, hp, 1, v, sc); end
                    join
                    chk((v[7:0] & m) == (d & m) && (nb == 8 || v[nb+int'(hp)] == 1'b0 || hp),
                        "R2 data bits", int'(v[7:0] & m), int'(d & m));
                    if (hp) chk(v[nb] == pexp, "R3 extra bit", v[nb], pexp);
                end

        // R4/R13 stop lengths with back-to-back characters
        cfg_par_mode = 2'b10;
        for (int lsel = 0; lsel < 2; lsel++)
            for (int code = 0; code < 16; code++) begin
                int len;
                logic [7:0] c2;
                len = lsel * 3;
                c2 = 8'(8'h3C + code * 5);
                cfg_len = 2'(len); cfg_stop = 4'(code);
                fork
                    begin
                        load(8'h55);
                        @(negedge clk);
                        while (tx_ready !== 1'b1) @(negedge clk);
                        load(c2);
                    end
                    begin
                        wait_start();
                        rx_frame(5 + len, 0, 1, v, sc);
                        rx_frame(5 + len, 0, 1, v2, sc2);
                    end
                join
                chk(sc == stop_exp(len, code), "R4 stop ticks", sc, stop_exp(len, code));
                chk(v2[7:0] == (c2 & 8'((1 << (5 + len)) - 1)), "R13 back-to-back char",
                    int'(v2[7:0]), int'(c2 & 8'((1 << (5 + len)) - 1)));
            end

        // R5/R6 flag timing
        cfg_len = 2'd3; cfg_stop = 4'd0;
        load(8'hA1);
        chk(tx_ready === 0, "R5 ready clears on load", tx_ready, 0);
        chk(tx_empty === 0, "R6 empty clears on load", tx_empty, 0);
        next_sample(); next_sample();
        chk(tx_ready === 1, "R5 ready after transfer", tx_ready, 1);
        chk(tx_empty === 0, "R6 not empty while shifting", tx_empty, 0);
        repeat (200) next_sample();
        chk(tx_empty === 1, "R6 empty after frame", tx_empty, 1);

        // R8/R12 disable mid-character with auto RTS
        cfg_rts_auto = 1; cfg_stop = 4'd15;
        fork
            begin
                load(8'hC6);
                repeat (40) next_sample();
                load(8'h0F);
                cmd(1);
            end
            begin wait_start(); rx_frame(8, 0, 0, v, sc); end
        join
        chk(v[7:0] == 8'hC6, "R8 in-flight char completes", int'(v[7:0]), 8'hC6);
        cnt = 0; bad = 0;
        while (rts_n === 1'b0 && cnt < 80) begin
            if (txd !== 1'b1) bad = 1;
            cnt++;
            next_sample();
        end
        chk(cnt == 48, "R12 rts rises one bit after stop", cnt, 48);
        repeat (40) begin next_sample(); if (txd !== 1'b1) bad = 1; end
        chk(!bad, "R8 held char not sent after disable", bad, 0);
        cmd(2); cmd(0);
        chk(rts_n === 0, "R12 rts reasserted by enable", rts_n, 0);
        chk(tx_empty === 1, "R9 holding discarded by reset", tx_empty, 1);

        // R12 auto off
        cfg_rts_auto = 0;
        fork
            begin load(8'h3E); repeat (40) next_sample(); cmd(1); end
            begin wait_start(); rx_frame(8, 0, 0, v, sc); end
        join
        cnt = 0;
        repeat (60) begin if (rts_n === 1'b0) cnt++; next_sample(); end
        chk(cnt == 60, "R12 rts unchanged with auto off", cnt, 60);
        cmd(0);

        // R9 reset command mid-character
        cfg_stop = 4'd0;
        fork
            load(8'h00);
            begin
                wait_start();
                repeat (40) next_sample();
                cmd(2);
                chk(txd === 1, "R9 line high after reset cmd", txd, 1);
                chk(tx_ready === 0 && tx_empty === 0, "R9 flags after reset cmd",
                    {tx_ready, tx_empty}, 0);
            end
        join
        bad = 0;
        repeat (40) begin next_sample(); if (txd !== 1'b1) bad = 1; end
        chk(!bad, "R9 stays inactive", bad, 0);
        load(8'h77);
        repeat (4) next_sample();
        chk(tx_ready === 0 && tx_empty === 0, "R7 load ignored while disabled",
            {tx_ready, tx_empty}, 0);
        bad = 0;
        repeat (40) begin next_sample(); if (txd !== 1'b1) bad = 1; end
        chk(!bad, "R7 nothing sent while disabled", bad, 0);
        cmd(0);
        chk(tx_ready === 1 && tx_empty === 1, "R7 holding still empty after enable",
            {tx_ready, tx_empty}, 3);

        // R10 clear-to-send gating, R7 load while full
        cfg_cts_en = 1; cts_n = 1;
        load(8'h5B);
        load(8'hE4);
        bad = 0;
        repeat (60) begin next_sample(); if (txd !== 1'b1) bad = 1; end
        chk(!bad, "R10 line marks while cts high", bad, 0);
        chk(tx_ready === 0, "R10 char held while cts high", tx_ready, 0);
        cts_n = 0;
        fork
            begin wait_start(); rx_frame(8, 0, 1, v, sc); end
            begin repeat (50) next_sample(); cts_n = 1; end
        join
        chk(v[7:0] == 8'h5B, "R10 mid-char cts change ignored", int'(v[7:0]), 8'h5B);
        chk(sc == 40, "R7 second load while full ignored", sc, 40);
        cts_n = 0; cfg_cts_en = 0;

        // R11 break
        cmd(3);
        bad = 0;
        repeat (50) begin next_sample(); if (txd !== 1'b0) bad = 1; end
        chk(!bad, "R11 continuous low during break", bad, 0);
        load(8'h9D);
        repeat (20) next_sample();
        chk(tx_ready === 0 && txd === 0, "R11 no start during break", {tx_ready, txd}, 0);
        cmd(4);
        wait_start();
        rx_frame(8, 0, 1, v, sc);
        chk(v[7:0] == 8'h9D, "R11 char sent after break", int'(v[7:0]), 8'h9D);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule